// File: doc/BRIEF.md
# Translation Look-Aside Buffer

This block is a small, fully associative cache of address translations that sits in front of a memory management unit. Every slot pairs a virtual page number (the tag) with a physical page number and a set of access-right bits. The unit presents a virtual page number on the lookup side and learns in the same cycle whether a translation is held, and if so which physical page and rights belong to it. After a successful page table walk the unit writes the result in through a one-cycle fill port.

The array is never loaded from memory and never written back. Its contents change only through fills and through a bulk flush. The flush happens whenever the processor mode input moves from system (0) to user (1). Slot choice on a fill is deterministic: a slot that already holds the same tag is reused, otherwise the lowest-numbered empty slot is used, otherwise a round-robin pointer names the victim.

Top module: `tlb_cache`

## Requirements
- R1: After reset every slot is empty, so every lookup misses.
- R2: A lookup whose page number matches a valid slot raises the hit output and drives that slot's physical page number and rights in the same cycle the page number is presented, with no clock edge in between.
- R3: A lookup that matches no valid slot drives hit low and drives the physical page number and rights outputs as all zeros.
- R4: A fill presented with fill enable high is stored at the next rising clock edge, and lookups return it from the following cycle on.
- R5: A fill whose tag is not held goes into the lowest-numbered empty slot when any slot is empty. Slots are therefore filled from slot 0 upward.
- R6: A fill whose tag is not held and that finds no empty slot replaces the slot named by a round-robin pointer. The pointer starts at slot 0, moves up by one after each such replacement, and wraps from the last slot back to slot 0.
- R7: A fill whose tag matches a valid slot overwrites that slot with the new physical page number and rights, no other slot changes, and the pointer does not move.
- R8: A clock edge at which the mode input is 1 while it was 0 at the previous edge empties every slot. Holding the mode at 1, or moving it from 1 to 0, leaves the contents untouched.
- R9: When a fill and a flush fall on the same clock edge, the flush wins and the fill is discarded, so no slot is valid afterwards.
- R10: A flush also returns the round-robin pointer to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | Processor mode: 0 system, 1 user; a 0-to-1 move flushes the array |
| lkp_vpn | input | VPN_W | Virtual page number looked up |
| lkp_hit | output | 1 | A valid slot holds lkp_vpn |
| lkp_ppn | output | PPN_W | Physical page number of the hit, zero on miss |
| lkp_rgt | output | RGT_W | Rights bits of the hit, zero on miss |
| fill_en | input | 1 | Write a translation at the next edge |
| fill_vpn | input | VPN_W | Virtual page number being filled |
| fill_ppn | input | PPN_W | Physical page number being filled |
| fill_rgt | input | RGT_W | Rights bits being filled |

## Verification
The bench builds the block with four slots and 8-bit virtual and physical page numbers. At that size the whole 256-entry lookup space can be swept after every fill or mode change. With four slots the round-robin pointer wraps after a handful of fills. The bench can therefore reach every victim position, the pointer reset on flush, and the fill-versus-flush collision in a short run, and it compares each result with its own model of the slot-choice rules.

// File: rtl/tlb_cache_pkg.sv
package tlb_cache_pkg;
  localparam int MAX_ENTRIES = 64;
  typedef logic [MAX_ENTRIES-1:0] entry_vec_t;

  // index of the lowest clear bit among the first n bits, 0 if none
  function automatic int lowest_clear(entry_vec_t v, int n);
    int pos;
    pos = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!v[i]) pos = i;
    end
    return pos;
  endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]       valid,
  input  logic [ENTRIES*VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]         key,
  output logic [ENTRIES-1:0]       match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i*VPN_W +: VPN_W] == key);
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fill_go,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] fill_match,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRIES-1:0] wr_vec,
  output logic               use_ptr
);
  logic [IDX_W-1:0] ptr_q;
  entry_vec_t       valid_ext;
  entry_vec_t       match_ext;
  logic             any_match;
  logic             any_free;

  always_comb begin
    valid_ext = '0;
    match_ext = '0;
    valid_ext[ENTRIES-1:0] = valid;
    match_ext[ENTRIES-1:0] = fill_match;
  end

  assign any_match = |fill_match;
  assign any_free  = ~&valid;
  assign use_ptr   = !any_match && !any_free;

  always_comb begin
    if (any_match)     wr_idx = IDX_W'(lowest_clear(~match_ext, ENTRIES));
    else if (any_free) wr_idx = IDX_W'(lowest_clear(valid_ext, ENTRIES));
    else               wr_idx = ptr_q;
  end

  always_comb begin
    wr_vec = '0;
    if (fill_go) wr_vec[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q <= '0;
    end else if (fill_go && use_ptr) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int RGT_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [ENTRIES-1:0]       wr_vec,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PPN_W-1:0]         wr_ppn,
  input  logic [RGT_W-1:0]         wr_rgt,
  output logic [ENTRIES-1:0]       valid,
  output logic [ENTRIES*VPN_W-1:0] tags,
  output logic [ENTRIES*PPN_W-1:0] ppns,
  output logic [ENTRIES*RGT_W-1:0] rgts
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid[i] <= 1'b0;
      end else if (wr_vec[i]) begin
        valid[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tags[i*VPN_W +: VPN_W] <= '0;
        ppns[i*PPN_W +: PPN_W] <= '0;
        rgts[i*RGT_W +: RGT_W] <= '0;
      end else if (wr_vec[i]) begin
        tags[i*VPN_W +: VPN_W] <= wr_vpn;
        ppns[i*PPN_W +: PPN_W] <= wr_ppn;
        rgts[i*RGT_W +: RGT_W] <= wr_rgt;
      end
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int RGT_W   = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             user_mode,
  input  logic [VPN_W-1:0] lkp_vpn,
  output logic             lkp_hit,
  output logic [PPN_W-1:0] lkp_ppn,
  output logic [RGT_W-1:0] lkp_rgt,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [RGT_W-1:0] fill_rgt
);
  logic                     mode_q;
  logic                     flush_w;
  logic                     fill_go_w;
  logic [ENTRIES-1:0]       valid_w;
  logic [ENTRIES*VPN_W-1:0] tags_w;
  logic [ENTRIES*PPN_W-1:0] ppns_w;
  logic [ENTRIES*RGT_W-1:0] rgts_w;
  logic [ENTRIES-1:0]       lkp_match_w;
  logic [ENTRIES-1:0]       fill_match_w;
  logic [ENTRIES-1:0]       wr_vec_w;
  logic [IDX_W-1:0]         wr_idx_w;
  logic                     use_ptr_w;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= user_mode;
  end

  assign flush_w   = user_mode && !mode_q;
  assign fill_go_w = fill_en && !flush_w;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .RGT_W(RGT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_w), .wr_vec(wr_vec_w),
    .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .wr_rgt(fill_rgt),
    .valid(valid_w), .tags(tags_w), .ppns(ppns_w), .rgts(rgts_w)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lkp_cam (
    .valid(valid_w), .tags(tags_w), .key(lkp_vpn), .match(lkp_match_w)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_cam (
    .valid(valid_w), .tags(tags_w), .key(fill_vpn), .match(fill_match_w)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush_w), .fill_go(fill_go_w),
    .valid(valid_w), .fill_match(fill_match_w),
    .wr_idx(wr_idx_w), .wr_vec(wr_vec_w), .use_ptr(use_ptr_w)
  );

  // read-out: OR of the matching slots, zero when nothing matches
  always_comb begin
    lkp_ppn = '0;
    lkp_rgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_match_w[i]) begin
        lkp_ppn |= ppns_w[i*PPN_W +: PPN_W];
        lkp_rgt |= rgts_w[i*RGT_W +: RGT_W];
      end
    end
  end

  assign lkp_hit = |lkp_match_w;
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 20,
  parameter int RGT_W   = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               fill_go,
  input logic [ENTRIES-1:0] valid,
  input logic [ENTRIES-1:0] fill_match,
  input logic [ENTRIES-1:0] wr_vec,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               lkp_hit,
  input logic [PPN_W-1:0]   lkp_ppn,
  input logic [RGT_W-1:0]   lkp_rgt
);
  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_hit |-> (lkp_ppn == '0 && lkp_rgt == '0));

  p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid[$past(wr_idx)]);

  p_prefer_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && fill_match == '0 && !(&valid)) |-> !valid[wr_idx]);

  p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_match) <= 1);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  p_flush_beats_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (wr_vec == '0));
endmodule

bind tlb_cache tlb_cache_chk #(
  .ENTRIES(ENTRIES), .PPN_W(PPN_W), .RGT_W(RGT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush_w), .fill_go(fill_go_w),
  .valid(valid_w), .fill_match(fill_match_w), .wr_vec(wr_vec_w),
  .wr_idx(wr_idx_w), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .lkp_rgt(lkp_rgt)
);

// File: tb/tlb_cache_tb_top.sv
module tlb_cache_tb_top;
  localparam int EN = 4;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          user_mode = 1'b0;
  logic [VW-1:0] lkp_vpn = '0;
  logic          lkp_hit;
  logic [PW-1:0] lkp_ppn;
  logic [RW-1:0] lkp_rgt;
  logic          fill_en = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic [RW-1:0] fill_rgt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the slot contents
  bit          m_val [EN];
  bit [VW-1:0] m_tag [EN];
  bit [PW-1:0] m_ppn [EN];
  bit [RW-1:0] m_rgt [EN];
  int          m_ptr = 0;
  bit          m_mode = 1'b0;

  always #10 clk = ~clk;

  tlb_cache #(.ENTRIES(EN), .VPN_W(VW), .PPN_W(PW), .RGT_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .lkp_rgt(lkp_rgt),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rgt(fill_rgt)
  );

  function automatic bit [PW-1:0] ppn_of(bit [VW-1:0] v, int gen);
    return PW'((v * 7 + gen * 29 + 3) & 8'hFF);
  endfunction

  task automatic m_flush();
    for (int i = 0; i < EN; i++) m_val[i] = 1'b0;
    m_ptr = 0;
  endtask

  task automatic m_fill(bit [VW-1:0] v, bit [PW-1:0] p, bit [RW-1:0] r);
    int slot;
    slot = -1;
    for (int i = 0; i < EN; i++) if (m_val[i] && m_tag[i] == v) slot = i;
    if (slot < 0) for (int i = EN - 1; i >= 0; i--) if (!m_val[i]) slot = i;
    if (slot < 0) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % EN;
    end
    m_val[slot] = 1'b1;
    m_tag[slot] = v;
    m_ppn[slot] = p;
    m_rgt[slot] = r;
  endtask

  // one clock step with optional fill and a mode value
  task automatic step(bit do_fill, bit [VW-1:0] v, bit [PW-1:0] p,
                      bit [RW-1:0] r, bit mode);
    bit fl;
    @(negedge clk);
    user_mode = mode;
    fill_en = do_fill;
    fill_vpn = v;
    fill_ppn = p;
    fill_rgt = r;
    @(negedge clk);
    fill_en = 1'b0;
    fl = mode && !m_mode;
    if (fl) m_flush();
    else if (do_fill) m_fill(v, p, r);
    m_mode = mode;
  endtask

  // exhaustive lookup sweep against the model
  task automatic sweep(string req);
    for (int v = 0; v < (1 << VW); v++) begin
      bit          eh;
      bit [PW-1:0] ep;
      bit [RW-1:0] er;
      eh = 1'b0; ep = '0; er = '0;
      for (int i = 0; i < EN; i++) begin
        if (m_val[i] && m_tag[i] == VW'(v)) begin
          eh = 1'b1; ep = m_ppn[i]; er = m_rgt[i];
        end
      end
      lkp_vpn = VW'(v);
      #1;
      checks++;
      if (lkp_hit !== eh || lkp_ppn !== ep || lkp_rgt !== er) begin
        errors++;
        $display("FAIL %s vpn=%0d actual hit=%0b ppn=%0h rgt=%0h expected hit=%0b ppn=%0h rgt=%0h",
                 req, v, lkp_hit, lkp_ppn, lkp_rgt, eh, ep, er);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_flush();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset empty, R3 miss outputs zero");

    // R4 R5 R2: slots fill from 0 upward, visible next cycle
    for (int k = 0; k < EN; k++) begin
      step(1'b1, VW'(10 + 10 * k), ppn_of(VW'(10 + 10 * k), 0), RW'(k), 1'b0);
      sweep("R2 R4 R5 fill into free slot");
    end

    // R6: full array, round robin through every slot and wrap
    for (int k = 0; k < EN + 2; k++) begin
      step(1'b1, VW'(100 + k), ppn_of(VW'(100 + k), 1), RW'(k + 1), 1'b0);
      sweep("R6 round-robin victim");
    end

    // R7: refill of a held tag overwrites in place
    step(1'b1, VW'(100 + EN + 1), ppn_of(VW'(100 + EN + 1), 5), 2'b11, 1'b0);
    sweep("R7 same tag overwrite");
    step(1'b1, VW'(200), ppn_of(VW'(200), 2), 2'b01, 1'b0);
    sweep("R7 pointer not moved by overwrite, R6");

    // R8: system to user flushes
    step(1'b0, '0, '0, '0, 1'b1);
    sweep("R8 flush on entry to user mode");
    step(1'b1, VW'(55), ppn_of(VW'(55), 3), 2'b10, 1'b1);
    step(1'b1, VW'(66), ppn_of(VW'(66), 3), 2'b01, 1'b1);
    sweep("R8 no flush while staying in user mode");
    step(1'b0, '0, '0, '0, 1'b0);
    sweep("R8 no flush on return to system mode");

    // move pointer away from zero: fill to full then one more
    for (int k = 0; k < EN - 1; k++)
      step(1'b1, VW'(150 + k), ppn_of(VW'(150 + k), 4), RW'(k), 1'b0);
    sweep("R5 refill to full");

    // R9: fill on the same edge as the flush is dropped
    step(1'b1, VW'(77), ppn_of(VW'(77), 6), 2'b11, 1'b1);
    sweep("R9 flush beats fill");

    // R10: pointer back at slot 0 after the flush
    step(1'b0, '0, '0, '0, 1'b0);
    for (int k = 0; k < EN + 1; k++) begin
      step(1'b1, VW'(220 + k), ppn_of(VW'(220 + k), 7), RW'(k), 1'b0);
    end
    sweep("R10 pointer reset by flush");

    // R3: boundary tags 0 and all-ones
    step(1'b1, VW'(0), 8'h5A, 2'b01, 1'b0);
    step(1'b1, {VW{1'b1}}, 8'hC3, 2'b10, 1'b0);
    sweep("R2 R3 boundary tags");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule